// File: doc/BRIEF.md
# Filtered Capture Edge Detector

This block watches one asynchronous capture pin and, when a qualifying edge is seen, latches the free-running timer count into a capture register. It also raises a sticky capture flag and an interrupt request. The pin is first brought into the clock domain by a synchroniser. It can then optionally be passed through a noise filter. The filter samples the synchronised level on every second clock and accepts a new level only after four identical samples in a row.

Three configuration inputs set the behaviour. One bit turns the filter on or off. A polarity bit picks a rising or a falling edge. A 3-bit field postpones the capture by a number of sample periods. The timer value that is stored is the one present on the clock edge at which the delayed capture fires. The timer itself lives outside the block. Software clears the flag through a one-cycle clear input.

Top module: `cap_edge_unit`

## Requirements
- R1: After reset, cap_val_o, cap_flag_o, irq_o and cap_stb_o are 0, and a pin held at 0 through and after reset produces no capture under either polarity.
- R2: With the filter off and a delay of 0, cap_stb_o goes high on the 4th rising clock edge after the pin change is first sampled, and stays high for exactly one cycle.
- R3: edge_sel_i = 1 selects a rising edge and edge_sel_i = 0 selects a falling edge. An edge of the other direction produces no capture.
- R4: With the filter on, the level is taken from one sample every second clock and changes only after four consecutive equal samples. A clean pin change with a delay of 0 gives the strobe on the 10th or 11th clock edge.
- R5: With the filter on, a pin pulse that lasts 5 clocks or fewer produces no capture.
- R6: A delay setting N from 1 to 7 fires the strobe on the N-th sample tick after the edge is recognised. Unfiltered, this is the (2N+3)-th or (2N+4)-th edge. Filtered, it is the (2N+9)-th or (2N+10)-th edge.
- R7: On a capture, cap_val_o takes the tmr_i value present just before the edge that raises cap_stb_o. It then holds that value until the next capture.
- R8: cap_flag_o is set with every capture and holds until flag_clr_i is high for a clock edge. A capture on the same edge as the clear leaves the flag set.
- R9: irq_o equals cap_flag_o AND irq_en_i, both taken at the same clock edge.
- R10: A qualifying edge that arrives while a delayed capture is pending is ignored. Only one capture results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw asynchronous capture pin |
| tmr_i | input | 16 | Current timer count |
| filt_en_i | input | 1 | 1 = four-sample noise filter in path |
| edge_sel_i | input | 1 | 1 = rising edge, 0 = falling edge |
| dly_i | input | 3 | Capture delay in sample periods |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the capture flag (write-zero pulse) |
| cap_stb_o | output | 1 | One-cycle capture strobe |
| cap_val_o | output | 16 | Captured timer value |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Unfiltered with a delay of 0, the strobe is due on exactly the 4th clock edge after the pin change, from two synchroniser flops, the level register and the output register. The bench counts edges and demands exactly 4. Paths that go through the divide-by-two sample tick have a phase that is not visible at the ports, so they are due in a two-edge window: 10–11 edges when filtered, plus 2N−1 edges for a delay of N. The bench checks that window. The captured value, the flag and irq_o are read on the same sample as the strobe. The bench's timer advances by one per edge, so the expected value is its count minus one. Rejection checks watch the outputs for 40 clocks after the stimulus.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CAP_TMR_W_DEF   = 16;
  localparam int CAP_SYNC_DEF    = 2;
  localparam int CAP_DIV_DEF     = 2;
  localparam int CAP_SAMPLES_DEF = 4;
  localparam int CAP_DLY_W_DEF   = 3;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } cap_edge_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int SAMPLE_DIV = 2,
  parameter int SAMPLES    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_en_i,
  input  logic din_i,
  output logic smp_o,
  output logic lvl_o
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int HW    = SAMPLES - 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  logic [DIV_W-1:0]   div_q;
  logic [HW-1:0]      hist_q;
  logic [SAMPLES-1:0] win;
  logic               lvl_q;

  // free-running sample tick, independent of the timer rate
  always_ff @(posedge clk) begin
    if (rst)                   div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  assign smp_o = (div_q == DIV_LAST);
  assign win   = {hist_q, din_i};

  always_ff @(posedge clk) begin
    if (rst)        hist_q <= '0;
    else if (smp_o) hist_q <= win[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                     lvl_q <= 1'b0;
    else if (!filt_en_i)         lvl_q <= din_i;
    else if (smp_o && (&win))    lvl_q <= 1'b1;
    else if (smp_o && !(|win))   lvl_q <= 1'b0;
  end

  assign lvl_o = lvl_q;

  // R4: while filtering, the accepted level only moves on a sample tick
  a_r4_level_on_tick: assert property (@(posedge clk) disable iff (rst)
    (filt_en_i && $past(filt_en_i) && !$stable(lvl_q)) |-> $past(smp_o));
endmodule

// File: rtl/cap_delay.sv
module cap_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic             smp_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic             busy_q;
  logic [DLY_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = busy_q && smp_i && (cnt_q == DLY_W'(1));
  assign fire_o    = (edge_i && !busy_q && (dly_i == '0)) || last_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (edge_i && (dly_i != '0)) begin
        busy_q <= 1'b1;
        cnt_q  <= dly_i;
      end
    end else if (smp_i) begin
      if (cnt_q == DLY_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10: a pending delay is never reloaded by a new edge
  a_r10_no_reload: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !smp_i) |=> $stable(cnt_q));
  // R6: nothing fires between sample ticks while a delay runs
  a_r6_fire_on_tick: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !smp_i) |-> !fire_o);
endmodule

// File: rtl/cap_edge_unit.sv
module cap_edge_unit
  import cap_pkg::*;
#(
  parameter int TMR_W      = CAP_TMR_W_DEF,
  parameter int SYNC_STG   = CAP_SYNC_DEF,
  parameter int SAMPLE_DIV = CAP_DIV_DEF,
  parameter int SAMPLES    = CAP_SAMPLES_DEF,
  parameter int DLY_W      = CAP_DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic             filt_en_i,
  input  logic             edge_sel_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic             cap_stb_o,
  output logic [TMR_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic      pin_s, smp, lvl, lvl_prev_q, edge_hit, fire, flag_nxt;
  cap_edge_e pol;

  cap_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s));

  cap_filter #(.SAMPLE_DIV(SAMPLE_DIV), .SAMPLES(SAMPLES)) u_filt (
    .clk(clk), .rst(rst), .filt_en_i(filt_en_i), .din_i(pin_s),
    .smp_o(smp), .lvl_o(lvl));

  always_ff @(posedge clk) begin
    if (rst) lvl_prev_q <= 1'b0;
    else     lvl_prev_q <= lvl;
  end

  assign pol      = cap_edge_e'(edge_sel_i);
  assign edge_hit = (pol == EDGE_RISE) ? (lvl && !lvl_prev_q)
                                       : (!lvl && lvl_prev_q);

  cap_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .edge_i(edge_hit), .smp_i(smp),
    .dly_i(dly_i), .fire_o(fire));

  assign flag_nxt = fire || (cap_flag_o && !flag_clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_stb_o  <= 1'b0;
      cap_val_o  <= '0;
      cap_flag_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      cap_stb_o  <= fire;
      cap_flag_o <= flag_nxt;
      irq_o      <= flag_nxt && irq_en_i;
      if (fire) cap_val_o <= tmr_i;
    end
  end

  // R2: strobe lasts one cycle
  a_r2_stb_single: assert property (@(posedge clk) disable iff (rst)
    cap_stb_o |=> !cap_stb_o);
  // R8: strobe always accompanied by the flag
  a_r8_stb_sets_flag: assert property (@(posedge clk) disable iff (rst)
    cap_stb_o |-> cap_flag_o);
  // R8: flag holds without a clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (cap_flag_o && !flag_clr_i) |=> cap_flag_o);
  // R9: request implies flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> cap_flag_o);
  // R7: captured value only changes with a strobe
  a_r7_val_held: assert property (@(posedge clk) disable iff (rst)
    !cap_stb_o |-> $stable(cap_val_o));
endmodule

// File: tb/sim_cap_edge_unit.sv
`timescale 1ns/1ps
module sim_cap_edge_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic [15:0] tcnt = '0;
  logic        filt = 1'b0, esel = 1'b1, irqen = 1'b1, clr = 1'b0;
  logic [2:0]  dly = '0;
  logic        stb, flag, irq;
  logic [15:0] val;
  int vectors = 0, miscomp = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 16'd1;

  cap_edge_unit u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .tmr_i(tcnt), .filt_en_i(filt),
    .edge_sel_i(esel), .dly_i(dly), .irq_en_i(irqen), .flag_clr_i(clr),
    .cap_stb_o(stb), .cap_val_o(val), .cap_flag_o(flag), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle(input logic lv);
    pin = lv;
    repeat (40) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_strobes(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (stb) n++;
    end
  endtask

  // rising edge, measure latency and check the captured value
  task automatic t_latency(input logic f, input logic [2:0] n,
                           input int lo, input int hi, input string req);
    int lat;
    logic [15:0] held;
    filt = f; dly = n; esel = 1'b1;
    settle(1'b0);
    pin = 1'b1;
    lat = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      lat++;
      if (stb) break;
    end
    chk(lat >= lo && lat <= hi, req, "strobe latency", lat, lo);
    chk(val == tcnt - 16'd1, "R7", "captured value", val, tcnt - 16'd1);
    chk(flag == 1'b1, "R8", "flag set on capture", flag, 1);
    held = val;
    @(negedge clk);
    chk(stb == 1'b0, "R2", "strobe one cycle", stb, 0);
    chk(val == held, "R7", "value held", val, held);
  endtask

  task automatic t_reset;
    int n;
    chk(stb == 0 && flag == 0 && irq == 0, "R1", "status after reset",
        {stb, flag, irq}, 0);
    chk(val == 0, "R1", "value after reset", val, 0);
    esel = 1'b0;
    count_strobes(20, n);
    chk(n == 0, "R1", "no capture from reset (falling)", n, 0);
    esel = 1'b1;
    count_strobes(20, n);
    chk(n == 0 && flag == 0, "R1", "no capture from reset (rising)", n, 0);
  endtask

  task automatic t_polarity;
    int n;
    filt = 1'b0; dly = '0; esel = 1'b1;
    settle(1'b1);
    pin = 1'b0;
    count_strobes(40, n);
    chk(n == 0 && flag == 0, "R3", "falling ignored when rising selected", n, 0);
    esel = 1'b0;
    settle(1'b1);
    pin = 1'b0;
    count_strobes(40, n);
    chk(n == 1, "R3", "falling edge captured", n, 1);
    settle(1'b0);
    pin = 1'b1;
    count_strobes(40, n);
    chk(n == 0, "R3", "rising ignored when falling selected", n, 0);
    esel = 1'b1;
  endtask

  task automatic t_noise;
    int n;
    filt = 1'b1; dly = '0; esel = 1'b1;
    settle(1'b0);
    pin = 1'b1;
    repeat (5) @(negedge clk);
    pin = 1'b0;
    count_strobes(40, n);
    chk(n == 0 && flag == 0, "R5", "short pulse rejected", n, 0);
    filt = 1'b0;
    settle(1'b0);
    pin = 1'b1;
    @(negedge clk);
    pin = 1'b0;
    count_strobes(40, n);
    chk(n == 1, "R5", "same pulse passes unfiltered", n, 1);
  endtask

  task automatic t_pending;
    int n;
    filt = 1'b0; dly = 3'd7; esel = 1'b1;
    settle(1'b0);
    pin = 1'b1;
    repeat (3) @(negedge clk);
    pin = 1'b0;
    repeat (3) @(negedge clk);
    pin = 1'b1;
    count_strobes(50, n);
    chk(n == 1, "R10", "second edge during delay ignored", n, 1);
    dly = '0;
  endtask

  task automatic t_flag_irq;
    filt = 1'b0; dly = '0; esel = 1'b1; irqen = 1'b1;
    settle(1'b0);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R9", "irq with flag and enable", irq, 1);
    irqen = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && flag == 1'b1, "R9", "irq masked, flag kept", irq, 0);
    irqen = 1'b1;
    // clear colliding with a new capture
    pin = 1'b0;
    repeat (10) @(negedge clk);
    pin = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(stb == 1'b1 && flag == 1'b1, "R8", "capture wins over clear",
        flag, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(flag == 1'b0 && irq == 1'b0, "R8", "clear drops flag and irq",
        flag, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency(1'b0, 3'd0, 4, 4, "R2");
    t_latency(1'b1, 3'd0, 10, 11, "R4");
    t_latency(1'b0, 3'd1, 5, 6, "R6");
    t_latency(1'b0, 3'd7, 17, 18, "R6");
    t_latency(1'b1, 3'd3, 15, 16, "R6");
    t_polarity();
    t_noise();
    t_pending();
    t_flag_irq();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule